// File: doc/BRIEF.md
# UV EPROM Mode Controller

This block is a synthesizable behavioural model of a byte-wide, ultraviolet-erasable, electrically programmable read-only memory. It takes the memory's active-low chip enable, output enable and program strobe as digital inputs. Two more flags stand in for analog levels: one says the programming supply is raised, and one says a high voltage is applied to address line 9. From these controls the block decodes one of seven operating modes. It drives a data bus with a separate enable, as a tri-state pad would. It also reports the decoded mode on a code output so that the decode can be observed directly.

The storage holds 2^ADDR_W words. Programming can only clear bits. A program pulse combines the new byte with the stored one by bitwise AND. The only way to restore ones is a synchronous erase-all input, which takes the place of UV exposure. The contents are not cleared by reset, just as the real array keeps its data without power. In signature mode the outputs return one of two fixed identifier bytes, and the lowest address bit picks which one. The control inputs pass through a synchronizer. A write happens once, on the rising edge of the synchronized program strobe.

Top module: `eprom_mode_ctrl`

## Requirements
- R1: With chip enable low, output enable low, programming flag low and identifier flag low, the mode code is 1 (read), data_oe is 1, and data_out carries the byte stored at addr.
- R2: With chip enable low, output enable high and programming flag low, the mode code is 2 (output off) and data_oe is 0.
- R3: With chip enable high, the mode code is 0 (standby) and data_oe is 0, whatever the other controls are.
- R4: A cycle with erase_all high sets every stored byte to 8'hFF.
- R5: With the programming flag high, chip enable low, output enable high and the strobe low, the mode code is 3 (program) and data_oe is 0. When the strobe returns high, the byte at addr becomes the old byte AND data_in, so no bit can go from 0 to 1.
- R6: A strobe held low for many cycles writes nothing while it stays low. Exactly one write happens, when the strobe rises, and it uses the data_in value present at that time.
- R7: With the programming flag high, chip enable low and output enable high, a high strobe gives mode code 5 (inhibit). The same code applies when output enable and the strobe are both low. A strobe pulse in standby or in inhibit leaves the contents unchanged.
- R8: With the programming flag high, chip enable and output enable low and the strobe high, the mode code is 4 (verify), data_oe is 1, and data_out carries the stored byte at addr.
- R9: With the identifier flag high, the programming flag low, and chip enable and output enable low, the mode code is 6 (signature). data_out is 8'h97 when addr[0] is 0 and 8'hD6 when addr[0] is 1, and every other address bit is ignored.
- R10: When erase_all coincides with the cycle in which a strobe-rise write would land, the erase wins and the byte reads 8'hFF.
- R11: A control change applied between clock edges shows on mode after the second rising edge. It shows on data_oe and data_out after the third.
- R12: During reset the mode code is 0, data_oe is 0 and data_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| prog_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High voltage on address line 9 (signature request) |
| erase_all | input | 1 | Synchronous erase of every byte to all ones |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Data to be programmed |
| data_out | output | DATA_W | Driven byte |
| data_oe | output | 1 | Bus drive enable for data_out |
| mode | output | 3 | Decoded mode code |

## Verification
A strobe-rise write and an erase-all request can land in the same clock edge. The bench provokes this by counting edges from the strobe release and raising erase_all so that it is sampled exactly on the edge where the write is applied. The verdict comes from a later verify read, which must show 8'hFF: if the write had won or arrived one edge late, the programmed zeros would remain. A second overlap is a strobe held low while the data changes, which is judged by which data value ends up stored.

// File: rtl/eprom_pkg.sv
// Package: shared mode codes, control bundle and idle values for the
// EPROM mode controller. Assumes byte-wide identifier codes.
package eprom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY   = 3'd0,
        MD_READ      = 3'd1,
        MD_OUTOFF    = 3'd2,
        MD_PROGRAM   = 3'd3,
        MD_VERIFY    = 3'd4,
        MD_INHIBIT   = 3'd5,
        MD_SIGNATURE = 3'd6
    } mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic vpp;
        logic idhv;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1,
                                  vpp: 1'b0, idhv: 1'b0};

endpackage

// File: rtl/eprom_sync.sv
// Module: multi-stage synchronizer for the control bundle.
// Assumes STAGES >= 1; every stage resets to the idle control values.
module eprom_sync
    import eprom_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  ctl_t d,
    output ctl_t q
);
    ctl_t chain [STAGES];

    // First stage captures the raw controls.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= CTL_IDLE;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= CTL_IDLE;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eprom_mode_dec.sv
// Module: combinational mode decode from synchronized controls.
// Priority: chip enable high forces standby; programming flag selects
// the program group; otherwise the read group (signature wins over read).
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  ctl_t  c,
    output mode_e mode
);
    // Decode the seven modes from the control bundle.
    always_comb begin
        if (c.ce_n) begin
            mode = MD_STANDBY;
        end else if (c.vpp) begin
            if (c.oe_n)       mode = c.pgm_n ? MD_INHIBIT : MD_PROGRAM;
            else if (c.pgm_n) mode = MD_VERIFY;
            else              mode = MD_INHIBIT;
        end else if (c.oe_n) begin
            mode = MD_OUTOFF;
        end else begin
            mode = c.idhv ? MD_SIGNATURE : MD_READ;
        end
    end
endmodule

// File: rtl/eprom_strobe.sv
// Module: write trigger. Fires one cycle when the synchronized strobe
// rises while the previous cycle's mode was program. Assumes the
// strobe input is already synchronized.
module eprom_strobe
    import eprom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pgm_n_s,
    input  mode_e mode,
    output logic  wr_en
);
    logic  pgm_prev;
    mode_e mode_prev;

    // Remember last cycle's strobe level and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_prev  <= 1'b1;
            mode_prev <= MD_STANDBY;
        end else begin
            pgm_prev  <= pgm_n_s;
            mode_prev <= mode;
        end
    end

    // Rising strobe that ends a program pulse.
    always_comb wr_en = pgm_n_s && !pgm_prev && (mode_prev == MD_PROGRAM);
endmodule

// File: rtl/eprom_array.sv
// Module: one-time-writable storage. A write ANDs data into the word;
// erase sets every word to all ones and wins over a write. Contents are
// deliberately not reset (non-volatile behaviour).
module eprom_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Erase everything, or clear bits of the addressed word.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '1;
        end else if (wr_en) begin
            words[addr] <= words[addr] & wdata;
        end
    end

    // Asynchronous read of the addressed word.
    always_comb rdata = words[addr];
endmodule

// File: rtl/eprom_out.sv
// Module: registered output stage. Selects stored data or identifier
// byte and raises the drive enable in read, verify and signature modes.
module eprom_out
    import eprom_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter logic [DATA_W-1:0] MAKER_ID = 8'h97,
    parameter logic [DATA_W-1:0] PART_ID  = 8'hD6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              sel_part,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_en;

    // Choose what the bus would carry in this mode.
    always_comb begin
        nxt_en   = 1'b0;
        nxt_data = '0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                nxt_en   = 1'b1;
                nxt_data = rd_word;
            end
            MD_SIGNATURE: begin
                nxt_en   = 1'b1;
                nxt_data = sel_part ? PART_ID : MAKER_ID;
            end
            default: ;
        endcase
    end

    // Register the bus value and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout    <= nxt_data;
            dout_en <= nxt_en;
        end
    end
endmodule

// File: rtl/eprom_mode_ctrl.sv
// Module: top of the EPROM mode controller. Synchronizes the controls,
// decodes the mode, triggers single writes on strobe release and drives
// the registered data bus. Assumes addr and data_in are held stable
// around a strobe release; erase_all is already synchronous.
module eprom_mode_ctrl
    import eprom_pkg::*;
#(
    parameter int                ADDR_W   = 10,
    parameter int                DATA_W   = 8,
    parameter int                SYNC_STG = 2,
    parameter logic [DATA_W-1:0] MAKER_ID = 8'h97,
    parameter logic [DATA_W-1:0] PART_ID  = 8'hD6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [2:0]        mode
);
    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    mode_e             mode_w;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;

    // Bundle the raw control pins.
    always_comb ctl_raw = '{ce_n: chip_en_n, oe_n: out_en_n, pgm_n: prog_n,
                            vpp: vpp_hi, idhv: id_hv};

    eprom_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    eprom_mode_dec u_dec (.c(ctl_s), .mode(mode_w));

    eprom_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .pgm_n_s(ctl_s.pgm_n),
        .mode(mode_w), .wr_en(wr_en)
    );

    eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .erase(erase_all), .wr_en(wr_en), .addr(addr),
        .wdata(data_in), .rdata(rd_word)
    );

    eprom_out #(.DATA_W(DATA_W), .MAKER_ID(MAKER_ID), .PART_ID(PART_ID)) u_out (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .rd_word(rd_word),
        .sel_part(addr[0]), .dout(data_out), .dout_en(data_oe)
    );

    assign mode = mode_w;
endmodule

// File: rtl/eprom_mode_ctrl_chk.sv
// Checker: temporal properties of the mode controller, bound to the top.
module eprom_mode_ctrl_chk
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              erase_all,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        mode,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic [DATA_W-1:0] rd_word
);
    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_READ) |=> (data_oe && data_out == $past(rd_word)));

    a_r2_outoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OUTOFF) |=> !data_oe);

    a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STANDBY) |=> !data_oe);

    a_r5_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(erase_all) && $stable(addr)) |-> ((rd_word & ~$past(rd_word)) == '0));

    a_r5_program_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PROGRAM) |=> !data_oe);

    a_r8_verify_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_VERIFY) |=> (data_oe && data_out == $past(rd_word)));

    a_r9_signature_id: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SIGNATURE) |=>
            (data_oe && data_out == ($past(addr[0]) ? DATA_W'(8'hD6) : DATA_W'(8'h97))));

    a_r10_erase_wins: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (rd_word == '1));
endmodule

bind eprom_mode_ctrl eprom_mode_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .erase_all(erase_all), .addr(addr),
    .mode(mode), .data_out(data_out), .data_oe(data_oe), .rd_word(rd_word)
);

// File: tb/eprom_mode_ctrl_test.sv
module eprom_mode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en_n = 1'b1, out_en_n = 1'b1, prog_n = 1'b1;
    logic       vpp_hi = 1'b0, id_hv = 1'b0, erase_all = 1'b0;
    logic [9:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic [2:0] mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eprom_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .prog_n(prog_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .erase_all(erase_all),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .mode(mode)
    );

    // ce_n oe_n pgm_n vpp hv addr din | mode en dout | requirement
    typedef struct packed {
        logic       ce_n, oe_n, pgm_n, vpp, hv;
        logic [9:0] a;
        logic [7:0] d;
        logic [2:0] emode;
        logic       een;
        logic [7:0] edout;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 10'd5,   8'h00, 3'd0,1'b0,8'h00, 4'd3},  // R3 standby
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 10'd5,   8'h00, 3'd1,1'b1,8'hFF, 4'd4},  // R4 erased reads FF, R1
        '{1'b0,1'b1,1'b1,1'b0,1'b0, 10'd5,   8'h00, 3'd2,1'b0,8'h00, 4'd2},  // R2 output off
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 10'd5,   8'h3C, 3'd3,1'b0,8'h00, 4'd5},  // R5 program
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 10'd5,   8'h3C, 3'd5,1'b0,8'h00, 4'd7},  // R7 inhibit
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 10'd5,   8'h3C, 3'd4,1'b1,8'h3C, 4'd8},  // R8 verify
        '{1'b0,1'b1,1'b0,1'b1,1'b0, 10'd5,   8'hF0, 3'd3,1'b0,8'h00, 4'd5},  // R5 second pulse
        '{1'b0,1'b1,1'b1,1'b1,1'b0, 10'd5,   8'hF0, 3'd5,1'b0,8'h00, 4'd7},  // R7
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 10'd5,   8'h00, 3'd1,1'b1,8'h30, 4'd5},  // R5 AND result
        '{1'b0,1'b0,1'b1,1'b0,1'b0, 10'd6,   8'h00, 3'd1,1'b1,8'hFF, 4'd1},  // R1 untouched
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 10'd0,   8'h00, 3'd6,1'b1,8'h97, 4'd9},  // R9 maker
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 10'd1,   8'h00, 3'd6,1'b1,8'hD6, 4'd9},  // R9 part
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 10'h3FE, 8'h00, 3'd6,1'b1,8'h97, 4'd9},  // R9 other bits
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 10'h2A1, 8'h00, 3'd6,1'b1,8'hD6, 4'd9},  // R9 other bits
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 10'd6,   8'h00, 3'd0,1'b0,8'h00, 4'd3},  // R3 vpp + strobe
        '{1'b1,1'b1,1'b1,1'b1,1'b0, 10'd6,   8'h00, 3'd0,1'b0,8'h00, 4'd7},  // R7 rise in standby
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 10'd6,   8'h00, 3'd4,1'b1,8'hFF, 4'd7},  // R7 no write
        '{1'b0,1'b0,1'b0,1'b1,1'b0, 10'd6,   8'h00, 3'd5,1'b0,8'h00, 4'd7},  // R7 oe+strobe low
        '{1'b0,1'b0,1'b1,1'b1,1'b0, 10'd6,   8'h00, 3'd4,1'b1,8'hFF, 4'd7},  // R7 no write
        '{1'b1,1'b0,1'b1,1'b0,1'b1, 10'd1,   8'h00, 3'd0,1'b0,8'h00, 4'd3}   // R3 hv ignored
    };

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic ce, input logic oe, input logic pg,
                         input logic vp, input logic hv,
                         input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        chip_en_n = ce; out_en_n = oe; prog_n = pg; vpp_hi = vp; id_hv = hv;
        addr = a; data_in = d;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic verify_byte(input string rq, input logic [9:0] a, input logic [7:0] exp);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00);
        settle();
        check(rq, int'(data_out), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R12 mode", int'(mode), 0);
        check("R12 oe", int'(data_oe), 0);
        check("R12 data", int'(data_out), 0);
        rst_n = 1'b1;

        // R4 erase everything first
        @(negedge clk); erase_all = 1'b1;
        @(negedge clk); erase_all = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ce_n, VEC[i].oe_n, VEC[i].pgm_n, VEC[i].vpp, VEC[i].hv,
                  VEC[i].a, VEC[i].d);
            settle();
            check($sformatf("R%0d mode v%0d", VEC[i].rq, i), int'(mode), int'(VEC[i].emode));
            check($sformatf("R%0d oe v%0d", VEC[i].rq, i), int'(data_oe), int'(VEC[i].een));
            if (VEC[i].een)
                check($sformatf("R%0d data v%0d", VEC[i].rq, i), int'(data_out), int'(VEC[i].edout));
        end

        // R11 latency from standby to read of address 5 (holds 8'h30)
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R11 mode after one edge", int'(mode), 0);
        @(posedge clk); @(negedge clk);
        check("R11 mode after two edges", int'(mode), 1);
        check("R11 oe after two edges", int'(data_oe), 0);
        @(posedge clk); @(negedge clk);
        check("R11 oe after three edges", int'(data_oe), 1);
        check("R11 data after three edges", int'(data_out), 8'h30);

        // R6 strobe held low while data changes: only the value at release counts
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd7, 8'h0F);
        repeat (8) @(posedge clk);
        @(negedge clk); data_in = 8'hFF;
        repeat (8) @(posedge clk);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd7, 8'hFF);
        settle();
        verify_byte("R6 held low no write", 10'd7, 8'hFF);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd7, 8'h0F);
        settle();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd7, 8'h0F);
        settle();
        verify_byte("R6 write at release", 10'd7, 8'h0F);

        // R10 erase lands on the same edge as the strobe-rise write
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd8, 8'h00);
        settle();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd8, 8'h00);
        @(posedge clk); @(posedge clk);
        @(negedge clk); erase_all = 1'b1;
        @(negedge clk); erase_all = 1'b0;
        settle();
        verify_byte("R10 erase beats write", 10'd8, 8'hFF);
        verify_byte("R4 erase restores ones", 10'd5, 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule